// File: doc/BRIEF.md
# Second-Level Interrupt Combiner with Bypass Lanes

This block sits between a bank of up to 32 level-sensitive peripheral interrupt lines and a parent interrupt controller. Software sets a single 32-bit enable word through a small register port and can read the live line levels through a 32-bit status word. A set of map masks, fixed by parameters, assigns lines to a small number of combined outputs. Each combined output rises when any line assigned to it is both high and enabled.

A forward mask, also fixed by a parameter, picks lines that skip the enable and combining logic. Each of those lines drives its own output bit directly, so the parent sees it as a plain wire. Lines that are in no map mask and not in the forward mask are unconnected. They can never raise any output.

There are no set or clear alias registers. To change individual enable bits, software reads the whole enable word, modifies it and writes the whole word back.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous reset, the enable word reads 0 and every combined output `agg_irq_o` is low.
- R2: A write with `reg_addr` = 0x0 stores the full 32-bit `reg_wdata` as the enable word. A read strobe `reg_rd` places the addressed word on `reg_rdata` one clock after the strobe edge.
- R3: A read with `reg_addr` = 0x4 returns the status word. Bit i of the status word is the level of `irq_lines[i]` at the strobe edge.
- R4: A write with `reg_addr` = 0x4 has no effect. The enable word and all outputs keep their values.
- R5: Combined output g equals the OR, over the lines in map mask g that are not forwarded, of (line AND enable bit). It is registered, so it follows its inputs one clock edge later.
- R6: The default map masks send lines 3, 4, 5, 7, 9, 10 and 11 (0xEB8) to `agg_irq_o[0]`, and lines 6 and 8 (0x140) to `agg_irq_o[1]`. The number of combined outputs equals the number of map-mask words.
- R7: For every line i set in the forward mask (default 0x7), `fwd_irq_o[i]` follows `irq_lines[i]` combinationally, whatever the enable word holds. A forwarded line never contributes to a combined output, even when a map mask also names it. Bits of `fwd_irq_o` at positions that are not forwarded are always 0.
- R8: A line that is in no map mask and not in the forward mask never asserts any output, even when its enable bit is set.
- R9: Enable bits at unmapped or forwarded positions are stored and read back as written, but they have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset: 0x0 is the enable word, 0x4 is the status word |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data, valid one clock after the read strobe |
| irq_lines | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| agg_irq_o | output | NUM_OUTS | Registered combined outputs toward the parent |
| fwd_irq_o | output | NUM_LINES | Direct per-line bypass outputs; only forwarded positions can be high |

## Verification
The bench builds the block with the default forward mask 0x7 and the default second map word 0x140. It widens the first map word to 0xEB9, so that line 0 is both mapped and forwarded. With that overlap the bench can check that a forwarded line stays out of a combined output even while its enable bit is set. Together the masks cover exactly bits 0 to 11, which leaves bits 12 to 31 as a known unconnected range for the checks with all enables set.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 4'h0;
  localparam logic [REG_AW-1:0] OFS_STATUS = 4'h4;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_combiner_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      lines,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      enable
);
  logic [W-1:0] rd_mux;

  // Only a full-word write to the enable offset is stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
    end else if (wr && addr == OFS_ENABLE) begin
      enable <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_ENABLE: rd_mux = enable;
      OFS_STATUS: rd_mux = lines;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int unsigned     W       = 32,
  parameter int unsigned     NG      = 2,
  parameter logic [NG*W-1:0] MAPS    = '0,
  parameter logic [W-1:0]    FWD     = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  lines,
  input  logic [W-1:0]  enable,
  output logic [NG-1:0] agg
);
  logic [W-1:0]  live;
  logic [NG-1:0] agg_d;

  // Forwarded positions are removed before any group sees them.
  assign live = lines & enable & ~FWD;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam logic [W-1:0] SEL = MAPS[g*W +: W];
    assign agg_d[g] = |(live & SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agg <= '0;
    end else begin
      agg <= agg_d;
    end
  end
endmodule

// File: rtl/irq_bypass.sv
module irq_bypass #(
  parameter int unsigned  W   = 32,
  parameter logic [W-1:0] FWD = '0
) (
  input  logic [W-1:0] lines,
  output logic [W-1:0] fwd
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    if (FWD[i]) begin : g_on
      assign fwd[i] = lines[i];
    end else begin : g_off
      assign fwd[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned                   NUM_LINES = 32,
  parameter int unsigned                   NUM_OUTS  = 2,
  parameter logic [NUM_OUTS*NUM_LINES-1:0] MAP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [NUM_LINES-1:0]          FWD_MASK  = 32'h0000_0007
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic [NUM_OUTS-1:0]  agg_irq_o,
  output logic [NUM_LINES-1:0] fwd_irq_o
);
  logic [NUM_LINES-1:0] enable_q;

  irq_cfg_regs #(.W(NUM_LINES)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .lines  (irq_lines),
    .rdata  (reg_rdata),
    .enable (enable_q)
  );

  irq_group_or #(
    .W    (NUM_LINES),
    .NG   (NUM_OUTS),
    .MAPS (MAP_MASKS),
    .FWD  (FWD_MASK)
  ) u_groups (
    .clk    (clk),
    .rst    (rst),
    .lines  (irq_lines),
    .enable (enable_q),
    .agg    (agg_irq_o)
  );

  irq_bypass #(
    .W   (NUM_LINES),
    .FWD (FWD_MASK)
  ) u_bypass (
    .lines (irq_lines),
    .fwd   (fwd_irq_o)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk
  import irq_combiner_pkg::*;
#(
  parameter int unsigned                   NUM_LINES = 32,
  parameter int unsigned                   NUM_OUTS  = 2,
  parameter logic [NUM_OUTS*NUM_LINES-1:0] MAP_MASKS = '0,
  parameter logic [NUM_LINES-1:0]          FWD_MASK  = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [REG_AW-1:0]    reg_addr,
  input logic [NUM_LINES-1:0] reg_wdata,
  input logic [NUM_LINES-1:0] reg_rdata,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [NUM_OUTS-1:0]  agg_irq_o,
  input logic [NUM_LINES-1:0] fwd_irq_o
);
  function automatic logic [NUM_LINES-1:0] live_union();
    logic [NUM_LINES-1:0] u;
    u = '0;
    for (int g = 0; g < NUM_OUTS; g++) u |= MAP_MASKS[g*NUM_LINES +: NUM_LINES];
    return u & ~FWD_MASK;
  endfunction

  localparam logic [NUM_LINES-1:0] LIVE = live_union();

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> agg_irq_o == '0); // R1

  AST_ENABLE_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr, 2) && $past(reg_addr, 2) == OFS_ENABLE && !$past(rst, 2) && !$past(rst)
     && $past(reg_rd) && !$past(reg_wr) && $past(reg_addr) == OFS_ENABLE)
    |-> reg_rdata == $past(reg_wdata, 2)); // R2

  AST_STATUS_RAW: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_STATUS) |=> reg_rdata == $past(irq_lines)); // R3

  AST_DEAD_LINES_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((irq_lines & LIVE) == '0) |=> agg_irq_o == '0); // R8

  AST_FWD_PASS: assert property (@(posedge clk) disable iff (rst)
    fwd_irq_o == (irq_lines & FWD_MASK)); // R7
endmodule

bind irq_combiner irq_combiner_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_OUTS  (NUM_OUTS),
  .MAP_MASKS (MAP_MASKS),
  .FWD_MASK  (FWD_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_lines (irq_lines),
  .agg_irq_o (agg_irq_o),
  .fwd_irq_o (fwd_irq_o)
);

// File: tb/sim_irq_combiner.sv
`timescale 1ns/1ps
module sim_irq_combiner;
  localparam int unsigned NL = 32;
  localparam int unsigned NO = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [NL-1:0] reg_wdata = '0;
  logic [NL-1:0] reg_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic [NO-1:0] agg_irq_o;
  logic [NL-1:0] fwd_irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_combiner #(
    .NUM_LINES (NL),
    .NUM_OUTS  (NO),
    .MAP_MASKS ({32'h0000_0140, 32'h0000_0EB9}),
    .FWD_MASK  (32'h0000_0007)
  ) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .agg_irq_o(agg_irq_o), .fwd_irq_o(fwd_irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NL-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NL-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [NL-1:0] d;
    chk("R1 agg after reset", 64'(agg_irq_o), 64'h0);
    rd(4'h0, d);
    chk("R1 enable after reset", 64'(d), 64'h0);
  endtask

  task automatic t_enable_rw();
    logic [NL-1:0] d;
    wr(4'h0, 32'hA5A5_5A5A);
    rd(4'h0, d);
    chk("R2 enable readback", 64'(d), 64'hA5A5_5A5A);
    wr(4'h0, 32'h0);
    rd(4'h0, d);
    chk("R2 enable cleared", 64'(d), 64'h0);
  endtask

  task automatic t_status();
    logic [NL-1:0] d;
    irq_lines = 32'h1234_5678;
    rd(4'h4, d);
    chk("R3 status raw", 64'(d), 64'h1234_5678);
    irq_lines = 32'h8000_0001;
    rd(4'h4, d);
    chk("R3 status raw 2", 64'(d), 64'h8000_0001);
    irq_lines = '0;
  endtask

  task automatic t_status_write();
    logic [NL-1:0] d;
    wr(4'h0, 32'h0000_0008);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, d);
    chk("R4 enable untouched", 64'(d), 64'h0000_0008);
    irq_lines = 32'h0000_0040;
    tick();
    chk("R4 line 6 stays disabled", 64'(agg_irq_o), 64'h0);
    irq_lines = '0;
    wr(4'h0, 32'h0);
    tick();
  endtask

  task automatic t_groups();
    wr(4'h0, 32'h0000_0FF8);
    tick();
    irq_lines = 32'h0000_0008;
    chk("R5 registered, not yet", 64'(agg_irq_o), 64'h0);
    tick();
    chk("R5 R6 line 3 -> out0", 64'(agg_irq_o), 64'h1);
    irq_lines = 32'h0000_0100;
    tick();
    chk("R6 line 8 -> out1", 64'(agg_irq_o), 64'h2);
    irq_lines = 32'h0000_0840;
    tick();
    chk("R6 lines 11,6 -> both", 64'(agg_irq_o), 64'h3);
    irq_lines = 32'h0000_0E80;
    tick();
    chk("R6 lines 7,9,10,11 -> out0", 64'(agg_irq_o), 64'h1);
    irq_lines = 32'h0000_0030;
    wr(4'h0, 32'h0000_0FC8);
    tick();
    chk("R5 disabled lines 4,5", 64'(agg_irq_o), 64'h0);
    irq_lines = '0;
    wr(4'h0, 32'h0);
    tick();
  endtask

  task automatic t_forward();
    irq_lines = 32'h0000_0005;
    #1;
    chk("R7 fwd follows lines", 64'(fwd_irq_o), 64'h5);
    wr(4'h0, 32'h0000_0001);
    tick();
    chk("R7 forwarded mapped line 0 not combined", 64'(agg_irq_o), 64'h0);
    irq_lines = 32'h0000_0002;
    #1;
    chk("R7 fwd line 1 only", 64'(fwd_irq_o), 64'h2);
    irq_lines = '0;
    wr(4'h0, 32'h0);
    tick();
  endtask

  task automatic t_unmapped();
    logic [NL-1:0] d;
    wr(4'h0, 32'hFFFF_F000);
    rd(4'h0, d);
    chk("R9 unmapped enable readback", 64'(d), 64'hFFFF_F000);
    irq_lines = 32'hFFFF_F000;
    tick();
    tick();
    chk("R8 unmapped agg silent", 64'(agg_irq_o), 64'h0);
    chk("R8 unmapped fwd silent", 64'(fwd_irq_o), 64'h0);
    wr(4'h0, 32'h0000_0007);
    irq_lines = 32'h0000_0000;
    tick();
    chk("R9 forwarded enable no agg", 64'(agg_irq_o), 64'h0);
    irq_lines = 32'h0000_0000;
    #1;
    chk("R9 fwd ignores enable", 64'(fwd_irq_o), 64'h0);
    irq_lines = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_status();
    t_status_write();
    t_groups();
    t_forward();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule